// File: doc/BRIEF.md
# Status Flag Generator and Condition Evaluator

This block sits beside an integer ALU. It takes the operands and the result of each operation and derives four status flags from them: negative, zero, carry and overflow. A two-bit operation class says how the result was produced: as a sum, as a difference, or by a logical or move operation whose carry comes from the operand shifter. The flags register loads only on cycles where the set-flags enable is high. At all other times it keeps its contents.

A 4-bit condition field is evaluated continuously against the stored flags. The resulting pass bit tells the issue logic whether the next instruction executes or is suppressed. Each flag is a single bit. A parameter sets the data width, and the most significant bit of the result is the sign.

Top module: `ccu_top`

## Requirements
- R1: When flags are set, N equals the most significant bit of `alu_res` and Z is 1 exactly when `alu_res` is all zeros.
- R2: For class 00 (add or compare-negative), C is the unsigned carry out of `opnd_a + opnd_b`.
- R3: For class 01 (subtract or compare), C is 1 when `opnd_a >= opnd_b` unsigned, and 0 when the subtraction borrows.
- R4: For classes 10 and 11 (logical or move), C takes the value of `shift_co`.
- R5: V is set on signed overflow: for an add when both operands share a sign that the result lacks, and for a subtract when the operand signs differ and the result sign differs from `opnd_a`.
- R6: For classes 10 and 11, V keeps its previous value.
- R7: While `set_flags` is 0, `stat_flags` does not change, whatever the other inputs do.
- R8: A synchronous active-high `rst` clears all four flags on the next clock edge.
- R9: The unsigned and single-flag conditions are 0=EQ (Z), 1=NE (!Z), 2=CS (C), 3=CC (!C), 4=MI (N), 5=PL (!N), 6=VS (V), 7=VC (!V), 8=HI (C and !Z), and 9=LS (!C or Z).
- R10: The signed conditions are 10=GE (N==V), 11=LT (N!=V), 12=GT (!Z and N==V) and 13=LE (Z or N!=V).
- R11: Code 14 (always) makes `pass` 1 and code 15 (never) makes it 0, whatever the flags hold.
- R12: `stat_flags` carries N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. Flags load on the clock edge, and `pass` follows the stored flags combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | DATA_W | First ALU operand |
| opnd_b | input | DATA_W | Second ALU operand (after the shifter) |
| alu_res | input | DATA_W | ALU result |
| op_kind | input | 2 | Operation class: 00 add, 01 subtract, 10/11 logical or move |
| shift_co | input | 1 | Carry out of the operand shifter |
| set_flags | input | 1 | Load the flags this cycle |
| cond | input | 4 | Condition code to evaluate |
| stat_flags | output | 4 | Stored flags {N,Z,C,V} |
| pass | output | 1 | Condition holds on the stored flags |

## Verification
The bench builds the block with DATA_W = 4. At that width every pair of operands can be swept for both add and subtract, which covers all 256 carry and overflow cases of each class, including both signed boundaries. Logical results are swept the same way, to show that the shifter carry is used and V is preserved. Each of the 16 condition codes is then checked against every reachable flag combination. That gives 12 combinations, because N and Z can never both be 1.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

    typedef enum logic [1:0] {
        OPK_ADD   = 2'b00,
        OPK_SUB   = 2'b01,
        OPK_LOGIC = 2'b10,
        OPK_MOVE  = 2'b11
    } op_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [3:0] {
        CND_EQ = 4'd0,  CND_NE = 4'd1,  CND_CS = 4'd2,  CND_CC = 4'd3,
        CND_MI = 4'd4,  CND_PL = 4'd5,  CND_VS = 4'd6,  CND_VC = 4'd7,
        CND_HI = 4'd8,  CND_LS = 4'd9,  CND_GE = 4'd10, CND_LT = 4'd11,
        CND_GT = 4'd12, CND_LE = 4'd13, CND_AL = 4'd14, CND_NV = 4'd15
    } cond_e;

    localparam int NUM_COND = 16;
    localparam flags_t FLAGS_RESET = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

    function automatic logic is_logic_class(op_kind_e k);
        return (k == OPK_LOGIC) || (k == OPK_MOVE);
    endfunction

    function automatic logic signed_ge(flags_t f);
        return f.n == f.v;
    endfunction

    function automatic logic cond_hit(cond_e c, flags_t f);
        logic r;
        case (c)
            CND_EQ:  r = f.z;
            CND_NE:  r = !f.z;
            CND_CS:  r = f.c;
            CND_CC:  r = !f.c;
            CND_MI:  r = f.n;
            CND_PL:  r = !f.n;
            CND_VS:  r = f.v;
            CND_VC:  r = !f.v;
            CND_HI:  r = f.c && !f.z;
            CND_LS:  r = !f.c || f.z;
            CND_GE:  r = signed_ge(f);
            CND_LT:  r = !signed_ge(f);
            CND_GT:  r = !f.z && signed_ge(f);
            CND_LE:  r = f.z || !signed_ge(f);
            CND_AL:  r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ccu_flag_calc.sv
module ccu_flag_calc
    import ccu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] res_i,
    input  op_kind_e          kind_i,
    input  logic              shift_co_i,
    input  logic              cur_v_i,
    output flags_t            nxt_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] sum_ext;
    logic            a_s, b_s, r_s;
    logic            add_ovf, sub_ovf;
    logic            no_borrow;

    assign sum_ext   = {1'b0, a_i} + {1'b0, b_i};
    assign no_borrow = (a_i >= b_i);
    assign a_s       = a_i[MSB];
    assign b_s       = b_i[MSB];
    assign r_s       = res_i[MSB];
    assign add_ovf   = (a_s == b_s) && (r_s != a_s);
    assign sub_ovf   = (a_s != b_s) && (r_s != a_s);

    always_comb begin
        nxt_o.n = r_s;
        nxt_o.z = (res_i == '0);
        case (kind_i)
            OPK_ADD: begin
                nxt_o.c = sum_ext[DATA_W];
                nxt_o.v = add_ovf;
            end
            OPK_SUB: begin
                nxt_o.c = no_borrow;
                nxt_o.v = sub_ovf;
            end
            default: begin
                nxt_o.c = shift_co_i;
                nxt_o.v = cur_v_i;
            end
        endcase
    end
endmodule

// File: rtl/ccu_cond_eval.sv
module ccu_cond_eval
    import ccu_pkg::*;
(
    input  flags_t     flags_i,
    input  logic [3:0] cond_i,
    output logic       pass_o
);
    logic [NUM_COND-1:0] hit_vec;

    for (genvar g = 0; g < NUM_COND; g++) begin : g_pred
        assign hit_vec[g] = cond_hit(cond_e'(g), flags_i);
    end

    assign pass_o = hit_vec[cond_i];
endmodule

// File: rtl/ccu_top.sv
module ccu_top
    import ccu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] alu_res,
    input  logic [1:0]        op_kind,
    input  logic              shift_co,
    input  logic              set_flags,
    input  logic [3:0]        cond,
    output logic [3:0]        stat_flags,
    output logic              pass
);
    flags_t flags_q;
    flags_t flags_nxt;

    ccu_flag_calc #(.DATA_W(DATA_W)) u_calc (
        .a_i        (opnd_a),
        .b_i        (opnd_b),
        .res_i      (alu_res),
        .kind_i     (op_kind_e'(op_kind)),
        .shift_co_i (shift_co),
        .cur_v_i    (flags_q.v),
        .nxt_o      (flags_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= FLAGS_RESET;
        end else if (set_flags) begin
            flags_q <= flags_nxt;
        end
    end

    ccu_cond_eval u_eval (
        .flags_i (flags_q),
        .cond_i  (cond),
        .pass_o  (pass)
    );

    assign stat_flags = flags_q;

    p_reset_clear_r8: assert property (@(posedge clk) rst |=> (stat_flags == 4'b0000));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !set_flags |=> $stable(stat_flags));

    p_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (set_flags && alu_res == '0) |=> (stat_flags[2] && !stat_flags[3]));

    p_sub_borrow_r3: assert property (@(posedge clk) disable iff (rst)
        (set_flags && op_kind == 2'b01 && opnd_a < opnd_b) |=> !stat_flags[1]);

    p_logic_keeps_v_r6: assert property (@(posedge clk) disable iff (rst)
        (set_flags && op_kind[1]) |=> (stat_flags[0] == $past(stat_flags[0])));

    p_shift_carry_r4: assert property (@(posedge clk) disable iff (rst)
        (set_flags && op_kind[1]) |=> (stat_flags[1] == $past(shift_co)));

    p_always_r11: assert property (@(posedge clk) disable iff (rst)
        (cond == 4'd14) |-> pass);

    p_never_r11: assert property (@(posedge clk) disable iff (rst)
        (cond == 4'd15) |-> !pass);

    p_eq_r9: assert property (@(posedge clk) disable iff (rst)
        (cond == 4'd0) |-> (pass == stat_flags[2]));
endmodule

// File: tb/test_ccu_top.sv
module test_ccu_top;
    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] opnd_a, opnd_b, alu_res;
    logic [1:0]   op_kind;
    logic         shift_co, set_flags;
    logic [3:0]   cond;
    logic [3:0]   stat_flags;
    logic         pass;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ccu_top #(.DATA_W(W)) i_ccu_top (
        .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .alu_res(alu_res), .op_kind(op_kind), .shift_co(shift_co),
        .set_flags(set_flags), .cond(cond), .stat_flags(stat_flags), .pass(pass)
    );

    task automatic chk_flags(string req, logic [3:0] exp);
        checks++;
        if (stat_flags !== exp) begin
            errors++;
            $display("FAIL %s flags actual=%b expected=%b", req, stat_flags, exp);
        end
    endtask

    task automatic chk_pass(string req, logic exp);
        checks++;
        if (pass !== exp) begin
            errors++;
            $display("FAIL %s pass cond=%0d flags=%b actual=%b expected=%b",
                     req, cond, stat_flags, pass, exp);
        end
    endtask

    // drive on the falling edge, let the rising edge load, sample 2 ns after it
    task automatic step(input int a, input int b, input int r, input int k,
                        input bit sc, input bit sf);
        @(negedge clk);
        opnd_a = a[W-1:0]; opnd_b = b[W-1:0]; alu_res = r[W-1:0];
        op_kind = k[1:0]; shift_co = sc; set_flags = sf;
        @(posedge clk);
        #2;
        set_flags = 1'b0;
    endtask

    function automatic bit ref_pass(bit n, bit z, bit c, bit v, int code);
        case (code)
            0: return z;            1: return !z;
            2: return c;            3: return !c;
            4: return n;            5: return !n;
            6: return v;            7: return !v;
            8: return c && !z;      9: return !c || z;
            10: return n == v;      11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int sgn(int x);
        return (x >= (1 << (W-1))) ? x - (1 << W) : x;
    endfunction

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; opnd_a = '0; opnd_b = '0; alu_res = '0;
        op_kind = 2'b00; shift_co = 1'b0; set_flags = 1'b0; cond = 4'd14;
        repeat (3) @(posedge clk);
        #2;
        chk_flags("R8 reset", 4'b0000);
        @(negedge clk); rst = 1'b0;

        // R2 R5 R1 add sweep
        for (int a = 0; a <= MASK; a++) begin
            for (int b = 0; b <= MASK; b++) begin
                int s; int r; bit ev;
                s = a + b; r = s & MASK;
                ev = ((sgn(a) + sgn(b)) > (MASK >> 1)) || ((sgn(a) + sgn(b)) < -(1 << (W-1)));
                step(a, b, r, 0, 1'b0, 1'b1);
                chk_flags("R2/R5 add", {r[W-1], r == 0, s > MASK, ev});
            end
        end

        // R3 R5 subtract sweep
        for (int a = 0; a <= MASK; a++) begin
            for (int b = 0; b <= MASK; b++) begin
                int r; int d; bit ev;
                r = (a - b) & MASK; d = sgn(a) - sgn(b);
                ev = (d > (MASK >> 1)) || (d < -(1 << (W-1)));
                step(a, b, r, 1, 1'b1, 1'b1);
                chk_flags("R3/R5 sub", {r[W-1], r == 0, a >= b, ev});
            end
        end

        // R4 R6 logical classes keep V
        for (int vset = 0; vset < 2; vset++) begin
            step(vset ? 4 : 0, vset ? 4 : 0, vset ? 8 : 0, 0, 1'b0, 1'b1);
            for (int r = 0; r <= MASK; r++) begin
                for (int sc = 0; sc < 2; sc++) begin
                    step(r ^ 5, 3, r, 2 + sc, sc[0], 1'b1);
                    chk_flags("R4/R6 logic", {r[W-1], r == 0, sc[0], vset[0]});
                end
            end
        end

        // R7 hold while set_flags low
        step(7, 1, 8, 0, 1'b0, 1'b1);   // N=1 Z=0 C=0 V=1
        for (int k = 0; k < 4; k++) begin
            step(15, 15, 0, k, 1'b1, 1'b0);
            chk_flags("R7 hold", 4'b1001);
        end

        // R9 R10 R11 R12 predicate sweep over reachable flags
        for (int vv = 0; vv < 2; vv++) begin
            for (int nz = 0; nz < 3; nz++) begin
                for (int cc = 0; cc < 2; cc++) begin
                    int r; bit n; bit z;
                    step(vv ? 4 : 0, vv ? 4 : 0, vv ? 8 : 0, 0, 1'b0, 1'b1);
                    r = (nz == 0) ? 1 : (nz == 1) ? 0 : 8;
                    n = (nz == 2); z = (nz == 1);
                    step(0, 0, r, 2, cc[0], 1'b1);
                    chk_flags("R12 order", {n, z, cc[0], vv[0]});
                    for (int code = 0; code < 16; code++) begin
                        @(negedge clk); cond = code[3:0];
                        #1;
                        chk_pass(code < 10 ? "R9" : code < 14 ? "R10" : "R11",
                                 ref_pass(n, z, cc[0], vv[0], code));
                    end
                end
            end
        end

        // R8 reset mid-run
        step(15, 15, 14, 0, 1'b0, 1'b1);
        @(negedge clk); rst = 1'b1; set_flags = 1'b1;
        @(posedge clk); #2;
        chk_flags("R8 mid reset", 4'b0000);
        @(negedge clk); rst = 1'b0; set_flags = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule